// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that finishes one instruction on every rising clock edge. Each cycle it fetches a word from a small instruction store at the current program counter and decodes it. It reads two registers, computes a result in a four-function arithmetic unit, optionally reads or writes a small data store, and commits the result and the next program counter together on the edge. It implements a fixed set of nine operations: word load and store, add, subtract, signed set-less-than, exclusive-or with an immediate, branch when two registers differ, an absolute jump, and a jump through a register.

One decoder looks at both the major opcode (bits 31..26) and the function field (bits 5..0). From these it produces every steering control, including a 2-bit arithmetic code and a flag that picks sign or zero widening of the 16-bit immediate. The only inputs are a clock and a synchronous active-high reset. A debug port shows the program counter and every register-file write that takes effect. The instruction store is loaded by the environment before reset is released.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and no register or data-store write occurs. The first instruction after release is fetched from address 0.
- R2: Register 0 always reads as zero. A write aimed at it has no effect and does not appear on the debug write port.
- R3: ADD (opcode 000000, funct 100000) writes rs+rt into rd, and SUB (opcode 000000, funct 100010) writes rs−rt into rd, both modulo 2^32.
- R4: SLT (opcode 000000, funct 101010) writes 1 into rd when rs < rt as signed 32-bit values, and 0 otherwise, including when they are equal.
- R5: XORI (opcode 001110) writes rs XOR the zero-extended 16-bit immediate (bits 15..0) into rt.
- R6: LW (opcode 100011) loads the word at rs + sign-extended offset into rt. SW (opcode 101011) stores rt at the same kind of address and writes no register. Both stores are indexed by address bits 7..2 of a 64-word array, and all other address bits are ignored.
- R7: BNE (opcode 000101) sets PC to PC+4+(sign-extended offset<<2) when rs≠rt, and to PC+4 otherwise. It writes no register.
- R8: J (opcode 000010) sets PC to {upper 4 bits of PC+4, bits 25..0 of the instruction, 00}.
- R9: JR (opcode 000000, funct 001000) sets PC to the value of register rs and writes no register.
- R10: Any other opcode, including 001000, and any other funct under opcode 000000 writes nothing and advances PC by 4.
- R11: Exactly one instruction completes per clock. The debug PC shows the instruction being executed in the current cycle, and the debug write port shows its register write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | A register write takes effect at the next edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The control-flow properties assume that every instruction word loaded into the store is one the environment intends to run, and that jump-register targets are word aligned. The test program only ever jumps through a register holding a multiple of 4. No data-store word is read before it has been written, because reading an unwritten word would give an unknown value. The instruction store is filled while reset is held. Every unused word holds a poison instruction that writes register 31, so if any skipped or mis-targeted fetch executes, it shows up on the debug port as an unexpected write.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN    = 32;
    localparam int REG_IDX = 5;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;
    localparam logic [5:0] OPC_BNE   = 6'b000101;
    localparam logic [5:0] OPC_XORI  = 6'b001110;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_SLT = 6'b101010;
    localparam logic [5:0] FN_JR  = 6'b001000;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_XOR = 2'b01,
        ALU_SUB = 2'b10,
        ALU_SLT = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic [5:0]         opc;
        logic [REG_IDX-1:0] rs;
        logic [REG_IDX-1:0] rt;
        logic [REG_IDX-1:0] rd;
        logic [4:0]         shamt;
        logic [5:0]         funct;
    } instr_t;

    typedef struct packed {
        logic    dst_rd;
        logic    load;
        alu_op_e alu_op;
        logic    store;
        logic    use_imm;
        logic    wr_reg;
        logic    sext;
        logic    jump;
        logic    jump_reg;
        logic    branch_ne;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '0;

    function automatic logic [XLEN-1:0] widen_imm(input logic [15:0] imm, input logic sext);
        return {{(XLEN-16){sext & imm[15]}}, imm};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  instr_t ins,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = CTRL_NOP;
        unique case (ins.opc)
            OPC_LOAD: begin
                ctl.load    = 1'b1;
                ctl.alu_op  = ALU_ADD;
                ctl.use_imm = 1'b1;
                ctl.wr_reg  = 1'b1;
                ctl.sext    = 1'b1;
            end
            OPC_STORE: begin
                ctl.store   = 1'b1;
                ctl.alu_op  = ALU_ADD;
                ctl.use_imm = 1'b1;
                ctl.sext    = 1'b1;
            end
            OPC_BNE: begin
                ctl.alu_op    = ALU_SUB;
                ctl.branch_ne = 1'b1;
                ctl.sext      = 1'b1;
            end
            OPC_XORI: begin
                ctl.alu_op  = ALU_XOR;
                ctl.use_imm = 1'b1;
                ctl.wr_reg  = 1'b1;
                ctl.sext    = 1'b0;
            end
            OPC_JUMP: begin
                ctl.jump = 1'b1;
            end
            OPC_RTYPE: begin
                ctl.sext = 1'b1;
                unique case (ins.funct)
                    FN_ADD: begin ctl.dst_rd = 1'b1; ctl.wr_reg = 1'b1; ctl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctl.dst_rd = 1'b1; ctl.wr_reg = 1'b1; ctl.alu_op = ALU_SUB; end
                    FN_SLT: begin ctl.dst_rd = 1'b1; ctl.wr_reg = 1'b1; ctl.alu_op = ALU_SLT; end
                    FN_JR:  begin ctl.jump_reg = 1'b1; ctl.alu_op = ALU_ADD; end
                    default: ctl = CTRL_NOP;
                endcase
            end
            default: ctl = CTRL_NOP;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_XOR: y = a ^ b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
    parameter int W        = 32,
    parameter int DEPTH    = 64,
    parameter bit WRITABLE = 1'b1,
    localparam int IW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd
);
    logic [W-1:0] mem [DEPTH];

    generate
        if (WRITABLE) begin : g_ram
            always_ff @(posedge clk) begin
                if (we) begin
                    mem[idx] <= wd;
                end
            end
        end else begin : g_rom
            logic unused_wr;
            assign unused_wr = ^{clk, we, wd};
            initial begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] = '0;
                end
            end
        end
    endgenerate

    assign rd = mem[idx];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic               clk,
    input  logic               rst,
    output logic [XLEN-1:0]    dbg_pc,
    output logic               dbg_wr_en,
    output logic [REG_IDX-1:0] dbg_wr_idx,
    output logic [XLEN-1:0]    dbg_wr_data
);
    localparam int IIDX_W = $clog2(IMEM_WORDS);
    localparam int DIDX_W = $clog2(DMEM_WORDS);

    logic [XLEN-1:0]    pc, pc4, next_pc, br_tgt, j_tgt;
    logic [XLEN-1:0]    instr_w, imm_ext, rs_val, rt_val, alu_b, alu_y, dm_rd, wr_data;
    logic [REG_IDX-1:0] wr_idx;
    logic               alu_zero, rf_we, dm_we;
    instr_t             ins;
    ctrl_t              ctl;

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= next_pc;
    end

    sc_wordmem #(.W(XLEN), .DEPTH(IMEM_WORDS), .WRITABLE(1'b0)) u_imem (
        .clk(clk), .we(1'b0), .idx(pc[IIDX_W+1:2]), .wd('0), .rd(instr_w)
    );

    assign ins = instr_t'(instr_w);

    sc_decode u_dec (.ins(ins), .ctl(ctl));

    sc_regfile #(.NREG(1 << REG_IDX), .W(XLEN)) u_rf (
        .clk(clk), .we(rf_we), .wa(wr_idx), .wd(wr_data),
        .ra_a(ins.rs), .ra_b(ins.rt), .rd_a(rs_val), .rd_b(rt_val)
    );

    assign imm_ext = widen_imm(instr_w[15:0], ctl.sext);
    assign alu_b   = ctl.use_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a(rs_val), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero)
    );

    logic unused_addr;
    assign unused_addr = ^{alu_y[XLEN-1:DIDX_W+2], alu_y[1:0]};

    assign dm_we = ctl.store & ~rst;

    sc_wordmem #(.W(XLEN), .DEPTH(DMEM_WORDS), .WRITABLE(1'b1)) u_dmem (
        .clk(clk), .we(dm_we), .idx(alu_y[DIDX_W+1:2]), .wd(rt_val), .rd(dm_rd)
    );

    assign wr_idx  = ctl.dst_rd ? ins.rd : ins.rt;
    assign wr_data = ctl.load ? dm_rd : alu_y;
    assign rf_we   = ctl.wr_reg & ~rst & (wr_idx != '0);

    assign pc4    = pc + XLEN'(4);
    assign br_tgt = pc4 + (imm_ext << 2);
    assign j_tgt  = {pc4[XLEN-1:XLEN-4], instr_w[25:0], 2'b00};

    always_comb begin
        if (ctl.jump_reg)                   next_pc = rs_val;
        else if (ctl.jump)                  next_pc = j_tgt;
        else if (ctl.branch_ne && !alu_zero) next_pc = br_tgt;
        else                                next_pc = pc4;
    end

    assign dbg_pc      = pc;
    assign dbg_wr_en   = rf_we;
    assign dbg_wr_idx  = wr_idx;
    assign dbg_wr_data = wr_data;

    // R1: the first cycle out of reset fetches from address zero
    a_r1_start_at_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == '0));

    // R7: a branch whose operands differ lands on the offset target
    a_r7_bne_taken: assert property (@(posedge clk) disable iff (rst)
        (ctl.branch_ne && (rs_val != rt_val)) |=> (pc == $past(pc) + 4 + ($past(imm_ext) << 2)));

    // R7 / R10: without any control transfer the PC steps by one word
    a_r10_sequential: assert property (@(posedge clk) disable iff (rst)
        (!ctl.jump && !ctl.jump_reg && !(ctl.branch_ne && (rs_val != rt_val))) |=> (pc == $past(pc) + 4));

    // R8: an absolute jump keeps the region bits and stays word aligned
    a_r8_jump_region: assert property (@(posedge clk) disable iff (rst)
        ctl.jump |=> ((pc[XLEN-1:XLEN-4] == $past(pc4[XLEN-1:XLEN-4])) && (pc[1:0] == 2'b00)));

    // R9: a register jump lands on the value read from rs
    a_r9_jump_reg: assert property (@(posedge clk) disable iff (rst)
        ctl.jump_reg |=> (pc == $past(rs_val)));

    // R6: a store cycle never writes the register file
    a_r6_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> !dbg_wr_en);
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sc_core u0 (
        .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
        .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data)
    );

    typedef struct {
        logic [31:0] pc;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] data;
        string       tag;
    } step_t;

    step_t sb[$];

    localparam logic [5:0] T_LW = 6'b100011, T_SW = 6'b101011, T_BNE = 6'b000101,
                           T_XORI = 6'b001110, T_ADDI = 6'b001000;
    localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010, F_SLT = 6'b101010,
                           F_JR = 6'b001000, F_OR = 6'b100101;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'b000010, tgt};
    endfunction

    task automatic put(input int addr, input logic [31:0] w);
        u0.u_imem.mem[addr >> 2] = w;
    endtask

    task automatic expect_step(input logic [31:0] pc, input logic we, input logic [4:0] idx,
                               input logic [31:0] data, input string tag);
        step_t s;
        s.pc = pc; s.we = we; s.idx = idx; s.data = data; s.tag = tag;
        sb.push_back(s);
    endtask

    // monitor: one scoreboard entry per executed instruction
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && sb.size() > 0) begin
                step_t s;
                bit ok;
                s  = sb.pop_front();
                ok = (dbg_pc == s.pc) && (dbg_wr_en == s.we) &&
                     (!s.we || ((dbg_wr_idx == s.idx) && (dbg_wr_data == s.data)));
                checks++;
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: pc=%h we=%b idx=%0d data=%h expected pc=%h we=%b idx=%0d data=%h",
                             s.tag, dbg_pc, dbg_wr_en, dbg_wr_idx, dbg_wr_data,
                             s.pc, s.we, s.idx, s.data);
                end
            end
        end
    end

    initial begin
        #1;
        for (int a = 0; a < 256; a += 4) put(a, enc_i(T_XORI, 5'd0, 5'd31, 16'h0BAD));
        put(0,   enc_i(T_XORI, 0, 1, 16'h8001));
        put(4,   enc_i(T_XORI, 0, 2, 16'h0005));
        put(8,   enc_r(1, 2, 3, F_ADD));
        put(12,  enc_r(2, 1, 4, F_SUB));
        put(16,  enc_r(4, 2, 5, F_SLT));
        put(20,  enc_r(2, 4, 6, F_SLT));
        put(24,  enc_r(2, 2, 7, F_SLT));
        put(28,  enc_i(T_XORI, 1, 0, 16'h00FF));
        put(32,  enc_r(0, 0, 8, F_ADD));
        put(36,  enc_i(T_SW, 2, 3, 16'd8));
        put(40,  enc_i(T_LW, 2, 9, 16'd7));
        put(44,  enc_i(T_SW, 6, 4, 16'hFFF0));
        put(48,  enc_i(T_LW, 0, 10, 16'h00F0));
        put(52,  enc_i(T_BNE, 5, 6, 16'd2));
        put(64,  enc_i(T_BNE, 6, 7, 16'd5));
        put(68,  enc_j(26'd20));
        put(80,  enc_i(T_XORI, 0, 12, 16'd100));
        put(84,  enc_r(12, 0, 0, F_JR));
        put(100, enc_i(T_ADDI, 0, 13, 16'd7));
        put(104, enc_r(0, 0, 13, F_OR));
        put(108, enc_i(T_XORI, 0, 14, 16'd3));
        put(112, enc_i(T_XORI, 0, 15, 16'd1));
        put(116, enc_r(14, 15, 14, F_SUB));
        put(120, enc_i(T_BNE, 14, 0, 16'hFFFE));
        put(124, enc_r(14, 10, 16, F_ADD));
        put(128, enc_j(26'd32));

        expect_step(0,   1, 1,  32'h0000_8001, "R5 xori zero-extend");
        expect_step(4,   1, 2,  32'd5,         "R5 xori small");
        expect_step(8,   1, 3,  32'h0000_8006, "R3 add");
        expect_step(12,  1, 4,  32'hFFFF_8004, "R3 sub wrap");
        expect_step(16,  1, 5,  32'd1,         "R4 slt negative<positive");
        expect_step(20,  1, 6,  32'd0,         "R4 slt positive vs negative");
        expect_step(24,  1, 7,  32'd0,         "R4 slt equal");
        expect_step(28,  0, 0,  32'd0,         "R2 write to r0 dropped");
        expect_step(32,  1, 8,  32'd0,         "R2 r0 reads zero");
        expect_step(36,  0, 0,  32'd0,         "R6 store no regwrite");
        expect_step(40,  1, 9,  32'h0000_8006, "R6 load low bits ignored");
        expect_step(44,  0, 0,  32'd0,         "R6 store negative offset");
        expect_step(48,  1, 10, 32'hFFFF_8004, "R6 load aliased index");
        expect_step(52,  0, 0,  32'd0,         "R7 bne taken");
        expect_step(64,  0, 0,  32'd0,         "R7 bne not taken");
        expect_step(68,  0, 0,  32'd0,         "R8 jump");
        expect_step(80,  1, 12, 32'd100,       "R8 jump target reached");
        expect_step(84,  0, 0,  32'd0,         "R9 jump register");
        expect_step(100, 0, 0,  32'd0,         "R10 unsupported opcode");
        expect_step(104, 0, 0,  32'd0,         "R10 unsupported funct");
        expect_step(108, 1, 14, 32'd3,         "R5 loop init");
        expect_step(112, 1, 15, 32'd1,         "R5 loop step");
        for (int k = 2; k >= 0; k--) begin
            expect_step(116, 1, 14, 32'(k),    "R3 loop decrement");
            expect_step(120, 0, 0,  32'd0,     "R7 backward branch");
        end
        expect_step(124, 1, 16, 32'hFFFF_8004, "R3 add after loop");
        for (int k = 0; k < 3; k++) expect_step(128, 0, 0, 32'd0, "R11 self jump");

        // R1: reset holds PC at zero and suppresses the first instruction's write
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            checks++;
            if (dbg_pc != 32'd0 || dbg_wr_en != 1'b0) begin
                errors++;
                $display("FAIL R1: pc=%h we=%b expected pc=%h we=%b", dbg_pc, dbg_wr_en, 32'd0, 1'b0);
            end
        end
        @(posedge clk);
        #5 rst = 1'b0;

        wait (sb.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R11: watchdog expired, %0d steps pending, expected 0", sb.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule